// File: doc/BRIEF.md
# Receive-Fill Xoff/Xon Scheduler

This block watches the fill count of a UART receive FIFO and decides when the local side must tell the remote station to pause or to resume sending. When the count reaches the trigger level, the block waits two character times and then asks the transmitter to send the pause character, or the pause pair. When the count later falls to the release point, it asks for the resume character, or the resume pair. If the count falls back to the release point before the wait is over, the pending pause is dropped and nothing is sent.

The trigger and release points come from one of two schemes. A four-entry step table uses 8, 16, 24 or 28, and releases at the table entry one step lower. The hysteresis scheme uses a free trigger level and releases below that level minus a hysteresis value. The hardware RTS logic uses the same hysteresis value. The transmitter reads `fc_req` and `fc_data` at each character boundary, gives them priority over ordinary FIFO data, and returns a one-cycle `fc_ack` for each character it takes.

The controller has seven named states:
- IDLE: the remote is free to send.
- ARMED: the pause delay is running.
- OFF_A: the first pause character is offered.
- OFF_B: the second pause character is offered.
- HOLD: the remote is held off.
- ON_A: the first resume character is offered.
- ON_B: the second resume character is offered.

The transitions are:
- TRIP: IDLE to ARMED.
- CANCEL: ARMED to IDLE.
- EXPIRE: ARMED to OFF_A.
- OFF_NEXT: OFF_A to OFF_B, in dual mode.
- OFF_DONE: OFF_A or OFF_B to HOLD.
- RELEASE: HOLD to ON_A.
- ON_NEXT: ON_A to ON_B, in dual mode.
- ON_DONE: ON_A or ON_B to IDLE.

Top module: `xoff_xon_sched`

## Requirements
- R1: After reset `fc_req` is 0 and `remote_held` is 0.
- R2: With `table_sel`=0, `step_idx` 0,1,2,3 selects trigger 8,16,24,28. With `table_sel`=1 the trigger is `trig_level`. A count below the trigger never starts a pause. A count at or above it in IDLE takes the TRIP transition.
- R3: The first pause request appears on the clock edge after the baud tick that completes 32×`frame_bits` ticks in ARMED. With no ticks, ARMED makes no progress.
- R4: With `dual_mode`=1, `xoff_a` is offered and then `xoff_b`, and on release `xon_a` and then `xon_b`. With `dual_mode`=0, only `xoff_a` and `xon_a` are offered.
- R5: While `fc_req`=1 and `fc_ack`=0, `fc_req` stays 1 and `fc_data` stays unchanged. Each `fc_ack` consumes exactly one character.
- R6: With `table_sel`=0, the resume is requested on the first cycle in HOLD with count ≤ the next lower step (0, 8, 16, 24 for `step_idx` 0..3). A count above that keeps HOLD without any request.
- R7: With `table_sel`=1, the release holds when count < `trig_level`−`hyst`. When `hyst` ≥ `trig_level`, it holds only when the count is 0.
- R8: If the release condition holds while ARMED, the block goes to IDLE on the next edge, and neither a pause nor a resume character is offered.
- R9: A resume is only offered after the full pause has been accepted. `remote_held` is 1 exactly in HOLD, ON_A and ON_B, and no pause is requested again while held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | 7 | Receive FIFO fill count |
| table_sel | input | 1 | 0 selects the step table, 1 selects trigger/hysteresis |
| step_idx | input | 2 | Step table entry (levels 8/16/24/28) |
| trig_level | input | 7 | Trigger level in hysteresis scheme |
| hyst | input | 7 | Hysteresis value |
| dual_mode | input | 1 | 1 selects two-character pause/resume |
| baud_tick16 | input | 1 | One pulse per 1/16 bit time |
| frame_bits | input | 4 | Bits per character frame |
| xoff_a | input | 8 | First pause character |
| xoff_b | input | 8 | Second pause character |
| xon_a | input | 8 | First resume character |
| xon_b | input | 8 | Second resume character |
| fc_ack | input | 1 | Transmitter took the offered character |
| fc_req | output | 1 | A flow-control character is offered |
| fc_data | output | 8 | Offered character |
| remote_held | output | 1 | The remote is currently held off |

## Verification
The bench sweeps every step-table entry in single and dual mode, two hysteresis settings including one where `hyst` exceeds the trigger, and three frame lengths. For each case it measures the exact edge on which the pause appears. A counter that is off by one moves that edge. A design that compares the trigger with `>` instead of `>=`, or that releases one step too early or too late, sends at the wrong count. The bench also drops the count during the delay to check the cancel, stops the baud tick, and holds back the acknowledge. A design that still sends a resume after a cancel, that keeps counting without ticks, or that changes its data before the acknowledge fails these checks.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ARMED, ST_OFF_A, ST_OFF_B, ST_HOLD, ST_ON_A, ST_ON_B
    } fc_state_t;

    // Step table: trigger level for each index
    function automatic int unsigned step_level(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 24;
            default: return 28;
        endcase
    endfunction
endpackage

// File: rtl/fc_threshold.sv
module fc_threshold #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic             table_sel,
    input  logic [1:0]       step_idx,
    input  logic [CNT_W-1:0] trig_level,
    input  logic [CNT_W-1:0] hyst,
    output logic             trip,
    output logic             release_ok
);
    import fc_pkg::*;

    logic [CNT_W-1:0] step_trig;
    logic [CNT_W-1:0] step_rel;

    always_comb begin
        step_trig = CNT_W'(step_level(step_idx));
        step_rel  = (step_idx == 2'd0) ? '0 : CNT_W'(step_level(step_idx - 2'd1));
        if (table_sel) begin
            trip = rx_count >= trig_level;
            if (trig_level > hyst)
                release_ok = rx_count < (trig_level - hyst);
            else
                release_ok = (rx_count == '0);
        end else begin
            trip       = rx_count >= step_trig;
            release_ok = rx_count <= step_rel;
        end
    end
endmodule

// File: rtl/fc_delay.sv
module fc_delay #(
    parameter int FB_W = 4,
    localparam int DLY_W = FB_W + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [FB_W-1:0] frame_bits,
    output logic            done
);
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] limit;

    // two characters of frame_bits bits at sixteen ticks per bit
    assign limit = {frame_bits, 5'd0};
    assign done  = run && tick && (cnt_q == limit - DLY_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + DLY_W'(1);
    end
endmodule

// File: rtl/xoff_xon_sched.sv
module xoff_xon_sched #(
    parameter int CNT_W = 7,
    parameter int FB_W  = 4,
    parameter int CH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             table_sel,
    input  logic [1:0]       step_idx,
    input  logic [CNT_W-1:0] trig_level,
    input  logic [CNT_W-1:0] hyst,
    input  logic             dual_mode,
    input  logic             baud_tick16,
    input  logic [FB_W-1:0]  frame_bits,
    input  logic [CH_W-1:0]  xoff_a,
    input  logic [CH_W-1:0]  xoff_b,
    input  logic [CH_W-1:0]  xon_a,
    input  logic [CH_W-1:0]  xon_b,
    input  logic             fc_ack,
    output logic             fc_req,
    output logic [CH_W-1:0]  fc_data,
    output logic             remote_held
);
    import fc_pkg::*;

    fc_state_t state_q, state_d;
    logic      trip, release_ok, dly_done;

    fc_threshold #(.CNT_W(CNT_W)) u_thr (
        .rx_count  (rx_count),
        .table_sel (table_sel),
        .step_idx  (step_idx),
        .trig_level(trig_level),
        .hyst      (hyst),
        .trip      (trip),
        .release_ok(release_ok)
    );

    fc_delay #(.FB_W(FB_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_ARMED),
        .tick      (baud_tick16),
        .frame_bits(frame_bits),
        .done      (dly_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trip) state_d = ST_ARMED;                    // TRIP
            ST_ARMED: if (release_ok) state_d = ST_IDLE;               // CANCEL
                      else if (dly_done) state_d = ST_OFF_A;           // EXPIRE
            ST_OFF_A: if (fc_ack) state_d = dual_mode ? ST_OFF_B : ST_HOLD;
            ST_OFF_B: if (fc_ack) state_d = ST_HOLD;                   // OFF_DONE
            ST_HOLD:  if (release_ok) state_d = ST_ON_A;               // RELEASE
            ST_ON_A:  if (fc_ack) state_d = dual_mode ? ST_ON_B : ST_IDLE;
            ST_ON_B:  if (fc_ack) state_d = ST_IDLE;                   // ON_DONE
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fc_req      = 1'b0;
        fc_data     = '0;
        remote_held = 1'b0;
        unique case (state_q)
            ST_OFF_A: begin fc_req = 1'b1; fc_data = xoff_a; end
            ST_OFF_B: begin fc_req = 1'b1; fc_data = xoff_b; end
            ST_HOLD:  remote_held = 1'b1;
            ST_ON_A:  begin fc_req = 1'b1; fc_data = xon_a; remote_held = 1'b1; end
            ST_ON_B:  begin fc_req = 1'b1; fc_data = xon_b; remote_held = 1'b1; end
            default:  ;
        endcase
    end

    AST_EXPIRE_NEEDS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_A && $past(state_q) == ST_ARMED) |-> $past(dly_done)) // R3
        else $error("pause offered before delay end");
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_req && !fc_ack && !(state_q == ST_HOLD)) |=> fc_req) // R5
        else $error("request dropped without ack");
    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && release_ok) |=> (state_q == ST_IDLE)) // R8
        else $error("cancel not taken");
    AST_XON_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON_A) |-> ($past(state_q) == ST_HOLD || $past(state_q) == ST_ON_A)) // R9
        else $error("resume without hold");
    AST_DUAL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_A && fc_ack && dual_mode) |=> (state_q == ST_OFF_B)) // R4
        else $error("second pause char skipped");
endmodule

// File: tb/sim_xoff_xon_sched.sv
module sim_xoff_xon_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rx_count = '0;
    logic       table_sel = 1'b0;
    logic [1:0] step_idx = '0;
    logic [6:0] trig_level = '0;
    logic [6:0] hyst = '0;
    logic       dual_mode = 1'b0;
    logic       baud_tick16 = 1'b1;
    logic [3:0] frame_bits = 4'd2;
    logic [7:0] xoff_a = 8'h13, xoff_b = 8'h93, xon_a = 8'h11, xon_b = 8'h91;
    logic       fc_ack = 1'b0;
    logic       fc_req;
    logic [7:0] fc_data;
    logic       remote_held;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    xoff_xon_sched u0 (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .table_sel(table_sel),
        .step_idx(step_idx), .trig_level(trig_level), .hyst(hyst),
        .dual_mode(dual_mode), .baud_tick16(baud_tick16), .frame_bits(frame_bits),
        .xoff_a(xoff_a), .xoff_b(xoff_b), .xon_a(xon_a), .xon_b(xon_b),
        .fc_ack(fc_ack), .fc_req(fc_req), .fc_data(fc_data), .remote_held(remote_held)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack1();
        fc_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fc_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // full pause/resume cycle; hi = trigger, stay = above release, lo = release
    task automatic full_cycle(input int hi, input int stay, input int lo, input bit dl,
                              input int fb);
        int dly;
        dly = 32 * fb;
        dual_mode = dl;
        frame_bits = 4'(fb);
        rx_count = 7'(hi - 1);
        cyc(50);
        chk("R2 below trigger", int'(fc_req), 0);
        rx_count = 7'(hi);
        cyc(dly);
        chk("R3 delay not yet over", int'(fc_req), 0);
        cyc(1);
        chk("R3 pause request", int'(fc_req), 1);
        chk("R4 first pause char", int'(fc_data), int'(xoff_a));
        cyc(3);
        chk("R5 request kept", int'(fc_req), 1);
        chk("R5 data kept", int'(fc_data), int'(xoff_a));
        chk("R9 not held before pause accepted", int'(remote_held), 0);
        ack1();
        if (dl) begin
            chk("R4 second pause char", int'(fc_req) * 256 + int'(fc_data), 256 + int'(xoff_b));
            ack1();
        end
        chk("R9 held after pause", int'(remote_held), 1);
        chk("R5 one char per ack", int'(fc_req), 0);
        rx_count = 7'(stay);
        cyc(20);
        chk("R6 no resume above release", int'(fc_req), 0);
        chk("R9 still held", int'(remote_held), 1);
        rx_count = 7'(lo);
        cyc(1);
        chk("R6 resume request", int'(fc_req), 1);
        chk("R4 first resume char", int'(fc_data), int'(xon_a));
        ack1();
        if (dl) begin
            chk("R4 second resume char", int'(fc_req) * 256 + int'(fc_data), 256 + int'(xon_b));
            ack1();
        end
        chk("R9 released", int'(fc_req) * 2 + int'(remote_held), 0);
    endtask

    initial begin
        cyc(3);
        chk("R1 reset req", int'(fc_req), 0);
        chk("R1 reset held", int'(remote_held), 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 after reset", int'(fc_req) * 2 + int'(remote_held), 0);

        // R2 R6 step table, all entries, single and dual
        table_sel = 1'b0;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 4; i++) begin
                int lv, rl;
                lv = (i == 3) ? 28 : 8 * (i + 1);
                rl = (i == 0) ? 0 : ((i == 3) ? 24 : 8 * i);
                step_idx = 2'(i);
                full_cycle(lv, rl + 1, rl, d[0], 2);
            end
        end

        // R3 frame length sweep
        for (int fb = 1; fb <= 3; fb++) begin
            step_idx = 2'd0;
            full_cycle(8, 1, 0, 1'b0, fb);
        end

        // R7 hysteresis scheme
        table_sel = 1'b1;
        trig_level = 7'd20;
        hyst = 7'd5;
        full_cycle(20, 15, 14, 1'b1, 2);
        trig_level = 7'd4;
        hyst = 7'd10;
        full_cycle(4, 1, 0, 1'b0, 2);

        // R8 cancel during delay
        table_sel = 1'b0;
        step_idx = 2'd1;
        frame_bits = 4'd2;
        rx_count = 7'd16;
        cyc(30);
        rx_count = 7'd8;
        cyc(200);
        chk("R8 no pause after cancel", int'(fc_req), 0);
        chk("R8 not held after cancel", int'(remote_held), 0);

        // R3 no ticks, no progress
        step_idx = 2'd0;
        dual_mode = 1'b0;
        baud_tick16 = 1'b0;
        rx_count = 7'd8;
        cyc(300);
        chk("R3 frozen without ticks", int'(fc_req), 0);
        baud_tick16 = 1'b1;
        cyc(63);
        chk("R3 resumed count not done", int'(fc_req), 0);
        cyc(1);
        chk("R3 resumed count done", int'(fc_req), 1);
        ack1();
        rx_count = 7'd0;
        cyc(1);
        chk("R6 resume after tick gap", int'(fc_data), int'(xon_a));
        ack1();
        chk("R9 idle at end", int'(remote_held), 0);

        finish_run();
    end

    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule